// File: doc/BRIEF.md
# Age-Ordered Load Queue

This block keeps the tags of in-flight loads of an out-of-order core in a circular queue, oldest at the head. When dispatch hands over a load, the queue records the load's sequence number, its address and the position the sibling store queue's tail had at that moment. A load that arrives while the store queue is empty gets a reserved "no older store" position instead. Commit frees entries from the head for every load no younger than the youngest committed sequence number. A pipeline squash removes, working back from the tail, every entry younger than the squash sequence number. All of these take effect in one clock.

Load dispatch is a valid/ready stream. `alloc_ready` is low while the queue holds `DEPTH-1` entries, because one slot always stays spare to tell full from empty. It is also low in any cycle in which a squash is requested. A load moves into the queue only in a cycle where `alloc_valid` and `alloc_ready` are both high, and dispatch must hold it until that happens. Commit, squash, the stall controls and the readback index are plain control pins. The block also reports its occupancy, and a free count for dispatch that takes the smaller of its own room and the store queue's room.

Sequence numbers are compared as plain unsigned values. Dispatch must present them in strictly increasing order, so the valid entries are always sorted by age.

Top module: `lq_age_queue`

## Requirements
- R1: After reset the queue is empty. `lq_count`, `lq_head` and `lq_tail` are 0, `stalled` is 0 and every `rd_valid` reads 0.
- R2: `alloc_ready` is 1 exactly when `lq_count < DEPTH-1` and `squash_en` is 0. On a transfer the load is written at index `alloc_lq_idx`, which equals `lq_tail`, and the tail and count advance at the next clock edge.
- R3: The stored store-queue position is `{1'b0, sq_tail}` when `sq_empty` is 0. When `sq_empty` is 1 it is all ones (`SQ_IDX_W+1` bits).
- R4: With `commit_en`, every entry whose sequence number is `<= commit_seq` leaves from the head in that cycle. The head advances by that number and the count drops by it.
- R5: With `squash_en`, every remaining entry whose sequence number is `> squash_seq` is invalidated and the tail moves back over it. Older entries stay untouched.
- R6: Commit is applied before squash in the same cycle. A squash blocks allocation in the cycle it is requested.
- R7: `free_count` equals `min(DEPTH - lq_count, sq_free) - 1`, and is 0 when that minimum is 0.
- R8: Head and tail wrap modulo `DEPTH`, which need not be a power of two. The tail always equals the head plus the count, modulo `DEPTH`.
- R9: `stall_set` marks the load at `stall_lq_idx` as waiting on a store, and `stall_release` clears the mark. A squash that removes the marked load clears the mark, and this takes priority over both controls.
- R10: `rd_valid`, `rd_seq`, `rd_addr` and `rd_sq_pos` show, combinationally, the registered contents of entry `rd_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Dispatch offers a load |
| alloc_ready | output | 1 | Queue accepts the offered load this cycle |
| alloc_seq | input | SEQ_W | Sequence number of the offered load |
| alloc_addr | input | ADDR_W | Address tag of the offered load |
| alloc_lq_idx | output | IDX_W | Slot the offered load will take |
| sq_tail | input | SQ_IDX_W | Current store-queue tail |
| sq_empty | input | 1 | Store queue holds no stores |
| sq_free | input | SQF_W | Store-queue free slots, spare included |
| commit_en | input | 1 | Commit request |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| squash_en | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Entries younger than this are removed |
| stall_set | input | 1 | Mark a load as waiting on a store |
| stall_lq_idx | input | IDX_W | Slot of the waiting load |
| stall_release | input | 1 | Clear the waiting mark |
| stalled | output | 1 | A waiting mark is held |
| stalled_idx | output | IDX_W | Slot of the marked load |
| lq_count | output | CNT_W | Valid entries |
| free_count | output | CNT_W | Free slots reported to dispatch |
| lq_head | output | IDX_W | Oldest slot |
| lq_tail | output | IDX_W | Next slot to fill |
| rd_idx | input | IDX_W | Readback slot |
| rd_valid | output | 1 | Readback slot is valid |
| rd_seq | output | SEQ_W | Readback sequence number |
| rd_addr | output | ADDR_W | Readback address |
| rd_sq_pos | output | SQ_IDX_W+1 | Readback store-queue position |

## Verification
`alloc_ready`, `alloc_lq_idx`, `free_count` and the readback fields are combinational, so they are checked about 1 ns after the inputs or the state they depend on settle. Allocation, commit, squash and the stall mark each take effect at exactly one clock edge. The bench drives all stimulus at the falling edge and advances its model at the next rising edge. It then checks counts, pointers, the stall mark and every slot through the readback port shortly after that rising edge, before the next inputs are driven.

// File: rtl/lq_pkg.sv
package lq_pkg;
  // modulo-depth pointer arithmetic; depth need not be a power of two
  function automatic int unsigned ring_fwd(int unsigned p, int unsigned n, int unsigned depth);
    int unsigned s;
    s = p + n;
    return (s >= depth) ? s - depth : s;
  endfunction

  function automatic int unsigned ring_back(int unsigned p, int unsigned n, int unsigned depth);
    return (p >= n) ? p - n : p + depth - n;
  endfunction
endpackage

// File: rtl/lq_tag_store.sv
module lq_tag_store #(
  parameter int DEPTH  = 8,
  parameter int SEQ_W  = 16,
  parameter int ADDR_W = 32,
  parameter int SQP_W  = 4,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [SEQ_W-1:0]  wr_seq,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [SQP_W-1:0]  wr_sqp,
  input  logic              commit_en,
  input  logic [SEQ_W-1:0]  commit_seq,
  input  logic              squash_en,
  input  logic [SEQ_W-1:0]  squash_seq,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DEPTH-1:0]  pop_vec,
  output logic [DEPTH-1:0]  kill_vec,
  output logic              rd_valid,
  output logic [SEQ_W-1:0]  rd_seq,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [SQP_W-1:0]  rd_sqp
);
  logic [DEPTH-1:0]  val_q;
  logic [SEQ_W-1:0]  seq_q  [DEPTH];
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [SQP_W-1:0]  sqp_q  [DEPTH];

  // per-slot age compares: commit pops first, squash judges what is left
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign pop_vec[i]  = commit_en && val_q[i] && (seq_q[i] <= commit_seq);
    assign kill_vec[i] = squash_en && val_q[i] && !pop_vec[i] && (seq_q[i] > squash_seq);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        seq_q[i]  <= '0;
        addr_q[i] <= '0;
        sqp_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (pop_vec[i] || kill_vec[i]) begin
          val_q[i] <= 1'b0;
        end else if (wr_en && (wr_idx == IDX_W'(i))) begin
          val_q[i]  <= 1'b1;
          seq_q[i]  <= wr_seq;
          addr_q[i] <= wr_addr;
          sqp_q[i]  <= wr_sqp;
        end
      end
    end
  end

  always_comb begin
    rd_valid = 1'b0;
    rd_seq   = '0;
    rd_addr  = '0;
    rd_sqp   = '0;
    if (32'(rd_idx) < DEPTH) begin
      rd_valid = val_q[rd_idx];
      rd_seq   = seq_q[rd_idx];
      rd_addr  = addr_q[rd_idx];
      rd_sqp   = sqp_q[rd_idx];
    end
  end

  // a slot being filled must be free
  AST_WRITE_FREE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !val_q[wr_idx]);  // R2
  // popped slots are gone next cycle
  AST_POP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_en && (pop_vec != '0)) |=> ((val_q & $past(pop_vec)) == '0));  // R4
endmodule

// File: rtl/lq_ptr_ctrl.sv
module lq_ptr_ctrl
  import lq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] pop_vec,
  input  logic [DEPTH-1:0] kill_vec,
  input  logic             squash_en,
  input  logic             alloc_fire,
  output logic [IDX_W-1:0] head_q,
  output logic [IDX_W-1:0] tail_q,
  output logic [CNT_W-1:0] count_q
);
  logic [CNT_W-1:0] n_pop, n_kill;
  logic [IDX_W-1:0] head_d, tail_d;
  logic [CNT_W-1:0] count_d;

  always_comb begin
    n_pop  = CNT_W'($countones(pop_vec));
    n_kill = CNT_W'($countones(kill_vec));
    head_d = IDX_W'(ring_fwd(32'(head_q), 32'(n_pop), DEPTH));
    if (squash_en)
      tail_d = IDX_W'(ring_back(32'(tail_q), 32'(n_kill), DEPTH));
    else if (alloc_fire)
      tail_d = IDX_W'(ring_fwd(32'(tail_q), 1, DEPTH));
    else
      tail_d = tail_q;
    count_d = count_q - n_pop - n_kill + CNT_W'(alloc_fire && !squash_en);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      head_q  <= head_d;
      tail_q  <= tail_d;
      count_q <= count_d;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(DEPTH - 1));  // R2
  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(head_q) < DEPTH) && (32'(tail_q) < DEPTH));  // R8
  AST_RING_CONSISTENT: assert property (@(posedge clk) disable iff (!rst_n)
    32'(tail_q) == ring_fwd(32'(head_q), 32'(count_q), DEPTH));  // R8
  AST_COMMIT_MOVES_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_vec != '0) |=> (head_q != $past(head_q)));  // R4
endmodule

// File: rtl/lq_stall_track.sv
module lq_stall_track #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] kill_vec,
  input  logic             stall_set,
  input  logic [IDX_W-1:0] stall_idx_in,
  input  logic             stall_release,
  output logic             stall_q,
  output logic [IDX_W-1:0] stall_idx_q
);
  logic kill_hit;

  assign kill_hit = stall_q && (32'(stall_idx_q) < DEPTH) && kill_vec[stall_idx_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stall_q     <= 1'b0;
      stall_idx_q <= '0;
    end else if (kill_hit) begin
      stall_q     <= 1'b0;
    end else if (stall_set) begin
      stall_q     <= 1'b1;
      stall_idx_q <= stall_idx_in;
    end else if (stall_release) begin
      stall_q     <= 1'b0;
    end
  end

  AST_STALL_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_q && (kill_vec != '0) && kill_vec[stall_idx_q]) |=> !stall_q);  // R9
endmodule

// File: rtl/lq_age_queue.sv
module lq_age_queue #(
  parameter int DEPTH    = 8,
  parameter int SQ_DEPTH = 8,
  parameter int SEQ_W    = 16,
  parameter int ADDR_W   = 32,
  localparam int IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W    = $clog2(DEPTH + 1),
  localparam int SQ_IDX_W = (SQ_DEPTH > 1) ? $clog2(SQ_DEPTH) : 1,
  localparam int SQP_W    = SQ_IDX_W + 1,
  localparam int SQF_W    = $clog2(SQ_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                alloc_valid,
  output logic                alloc_ready,
  input  logic [SEQ_W-1:0]    alloc_seq,
  input  logic [ADDR_W-1:0]   alloc_addr,
  output logic [IDX_W-1:0]    alloc_lq_idx,
  input  logic [SQ_IDX_W-1:0] sq_tail,
  input  logic                sq_empty,
  input  logic [SQF_W-1:0]    sq_free,
  input  logic                commit_en,
  input  logic [SEQ_W-1:0]    commit_seq,
  input  logic                squash_en,
  input  logic [SEQ_W-1:0]    squash_seq,
  input  logic                stall_set,
  input  logic [IDX_W-1:0]    stall_lq_idx,
  input  logic                stall_release,
  output logic                stalled,
  output logic [IDX_W-1:0]    stalled_idx,
  output logic [CNT_W-1:0]    lq_count,
  output logic [CNT_W-1:0]    free_count,
  output logic [IDX_W-1:0]    lq_head,
  output logic [IDX_W-1:0]    lq_tail,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic                rd_valid,
  output logic [SEQ_W-1:0]    rd_seq,
  output logic [ADDR_W-1:0]   rd_addr,
  output logic [SQP_W-1:0]    rd_sq_pos
);
  logic [DEPTH-1:0] pop_vec, kill_vec;
  logic             alloc_fire;
  logic [SQP_W-1:0] sq_pos_tag;

  assign alloc_ready  = !squash_en && (lq_count < CNT_W'(DEPTH - 1));
  assign alloc_fire   = alloc_valid && alloc_ready;
  assign alloc_lq_idx = lq_tail;
  assign sq_pos_tag   = sq_empty ? {SQP_W{1'b1}} : {1'b0, sq_tail};

  lq_tag_store #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W), .SQP_W(SQP_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(alloc_fire), .wr_idx(lq_tail), .wr_seq(alloc_seq), .wr_addr(alloc_addr), .wr_sqp(sq_pos_tag),
    .commit_en(commit_en), .commit_seq(commit_seq),
    .squash_en(squash_en), .squash_seq(squash_seq),
    .rd_idx(rd_idx), .pop_vec(pop_vec), .kill_vec(kill_vec),
    .rd_valid(rd_valid), .rd_seq(rd_seq), .rd_addr(rd_addr), .rd_sqp(rd_sq_pos)
  );

  lq_ptr_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .pop_vec(pop_vec), .kill_vec(kill_vec),
    .squash_en(squash_en), .alloc_fire(alloc_fire),
    .head_q(lq_head), .tail_q(lq_tail), .count_q(lq_count)
  );

  lq_stall_track #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_stall (
    .clk(clk), .rst_n(rst_n), .kill_vec(kill_vec),
    .stall_set(stall_set), .stall_idx_in(stall_lq_idx), .stall_release(stall_release),
    .stall_q(stalled), .stall_idx_q(stalled_idx)
  );

  // dispatch room: tighter of the two queues, less the spare slot
  always_comb begin
    int lfree, m;
    lfree = DEPTH - 32'(lq_count);
    m = (lfree < 32'(sq_free)) ? lfree : 32'(sq_free);
    free_count = (m == 0) ? '0 : CNT_W'(m - 1);
  end

  AST_FREE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(free_count) + 32'(lq_count)) <= DEPTH - 1);  // R7
  AST_SQUASH_BLOCKS_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    (squash_en && alloc_valid && !commit_en) |=> (lq_count <= $past(lq_count)));  // R6
  AST_EMPTY_AFTER_RESET: assert property (@(posedge clk)
    !rst_n |=> (lq_count == '0) && !stalled);  // R1
endmodule

// File: tb/sim_lq_age_queue.sv
`timescale 1ns/1ps
module sim_lq_age_queue;
  localparam int D = 6, SQD = 4, SW = 16, AW = 16;
  localparam int IW = 3, CW = 3, SQIW = 2, SQPW = 3, SQFW = 3;

  logic clk = 0, rst_n = 0;
  logic alloc_valid = 0, alloc_ready;
  logic [SW-1:0] alloc_seq = 0, commit_seq = 0, squash_seq = 0, rd_seq;
  logic [AW-1:0] alloc_addr = 0, rd_addr;
  logic [IW-1:0] alloc_lq_idx, stall_lq_idx = 0, stalled_idx, lq_head, lq_tail, rd_idx = 0;
  logic [SQIW-1:0] sq_tail = 0;
  logic sq_empty = 1, commit_en = 0, squash_en = 0, stall_set = 0, stall_release = 0, stalled, rd_valid;
  logic [SQFW-1:0] sq_free = 4;
  logic [CW-1:0] lq_count, free_count;
  logic [SQPW-1:0] rd_sq_pos;

  lq_age_queue #(.DEPTH(D), .SQ_DEPTH(SQD), .SEQ_W(SW), .ADDR_W(AW)) u0 (.*);

  always #4 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  int mhead = 0, mtail = 0, mcnt = 0, nseq = 10;
  bit mval [D];
  int mseq [D], maddr [D], msqp [D];
  bit mstall = 0;
  int mstidx = 0;

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nxt(int p); return (p + 1 >= D) ? 0 : p + 1; endfunction
  function automatic int prv(int p); return (p == 0) ? D - 1 : p - 1; endfunction

  task automatic check_state();
    int m;
    chk("R4 count", int'(lq_count), mcnt);
    chk("R8 head", int'(lq_head), mhead);
    chk("R8 tail", int'(lq_tail), mtail);
    chk("R2 alloc index", int'(alloc_lq_idx), mtail);
    chk("R9 stalled", int'(stalled), int'(mstall));
    if (mstall) chk("R9 stalled index", int'(stalled_idx), mstidx);
    m = (D - mcnt < int'(sq_free)) ? D - mcnt : int'(sq_free);
    chk("R7 free count", int'(free_count), (m == 0) ? 0 : m - 1);
    for (int i = 0; i < D; i++) begin
      rd_idx = IW'(i);
      #0.4;
      chk("R10 valid", int'(rd_valid), int'(mval[i]));
      if (mval[i]) begin
        chk("R10 seq", int'(rd_seq), mseq[i]);
        chk("R10 addr", int'(rd_addr), maddr[i]);
        chk("R3 sq position", int'(rd_sq_pos), msqp[i]);
      end
    end
  endtask

  // drive at falling edge, update model, check after the rising edge
  task automatic step(bit av, bit ce, int cs, bit se, int ss, bit st, int sti, bit sr, bit sqe, int sqt, int sqf);
    bit fire, hit;
    @(negedge clk);
    alloc_valid = av; alloc_seq = SW'(nseq); alloc_addr = AW'(nseq * 37 + 5);
    commit_en = ce; commit_seq = SW'(cs); squash_en = se; squash_seq = SW'(ss);
    stall_set = st; stall_lq_idx = IW'(sti); stall_release = sr;
    sq_empty = sqe; sq_tail = SQIW'(sqt); sq_free = SQFW'(sqf);
    #1;
    chk("R2 R6 ready", int'(alloc_ready), int'(mcnt < D - 1 && !se));
    fire = av && mcnt < D - 1 && !se;
    if (ce) while (mcnt > 0 && mseq[mhead] <= cs) begin
      mval[mhead] = 0; mhead = nxt(mhead); mcnt--;
    end
    hit = 0;
    if (se) while (mcnt > 0 && mseq[prv(mtail)] > ss) begin
      mtail = prv(mtail); mval[mtail] = 0; mcnt--;
      if (mstall && mstidx == mtail) hit = 1;
    end
    if (fire) begin
      mval[mtail] = 1; mseq[mtail] = nseq; maddr[mtail] = (nseq * 37 + 5) & 16'hffff;
      msqp[mtail] = sqe ? 7 : sqt; mtail = nxt(mtail); mcnt++; nseq++;
    end
    if (hit) mstall = 0;
    else if (st) begin mstall = 1; mstidx = sti; end
    else if (sr) mstall = 0;
    @(posedge clk);
    #1;
    check_state();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < D; i++) mval[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    check_state();  // R1 reset state
    @(negedge clk); rst_n = 1;
    // R2 fill to the full point with the store queue non-empty, R3 position tag
    for (int i = 0; i < 6; i++) step(1, 0, 0, 0, 0, 0, 0, 0, 0, i & 3, 4);
    chk("R2 full blocks", int'(mcnt), D - 1);
    // R4 commit two oldest
    step(0, 1, 11, 0, 0, 0, 0, 0, 0, 0, 2);
    // R3 empty store queue gives all-ones position, R8 wrap of tail
    step(1, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0, 0, 1, 0, 1);
    // R9 stall on the youngest, R5 squash removes it and clears the mark
    step(0, 0, 0, 0, 0, 1, prv(mtail), 0, 0, 0, 4);
    step(1, 0, 0, 1, mseq[prv(prv(mtail))] - 1, 0, 0, 0, 0, 0, 4);
    // R6 commit and squash together, allocation blocked
    step(1, 1, mseq[mhead], 1, mseq[nxt(mhead)], 0, 0, 0, 0, 1, 3);
    // R5 squash everything
    step(0, 0, 0, 1, 0, 0, 0, 0, 1, 0, 4);
    // R9 set then release
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 2, 4);
    step(0, 0, 0, 0, 0, 1, mhead, 0, 0, 2, 4);
    step(0, 0, 0, 0, 0, 0, 0, 1, 0, 2, 4);
    // random mix of every operation
    for (int k = 0; k < 1500; k++) begin
      int cs, ss, r;
      bit ce, se;
      r = int'($urandom_range(0, 99));
      ce = r < 35;
      se = int'($urandom_range(0, 99)) < 15;
      cs = (mcnt > 0) ? mseq[(mhead + int'($urandom_range(0, mcnt - 1))) % D] - int'($urandom_range(0, 1)) : nseq - 1;
      ss = (mcnt > 0) ? mseq[(mhead + int'($urandom_range(0, mcnt - 1))) % D] - int'($urandom_range(0, 1)) : nseq - 1;
      step($urandom_range(0, 99) < 70, ce, cs, se, ss,
           $urandom_range(0, 99) < 10, (mhead + int'($urandom_range(0, 4))) % D,
           $urandom_range(0, 99) < 5, $urandom_range(0, 3) == 0,
           int'($urandom_range(0, 3)), int'($urandom_range(0, 4)));
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule